// File: doc/BRIEF.md
# Shaped On-Off Keying Amplitude Ramp

This block scales a stream of signed waveform samples by an amplitude factor. When shaping is active, the factor moves toward a destination one unit at a time instead of jumping. A keying input selects the destination. High selects a programmed full-scale value and low selects zero. Burst edges are therefore softened rather than switched abruptly. A programmable ramp-rate timer sets the spacing between steps. An update strobe can restart the timer's interval, depending on a control bit.

The multiplier can also use a fixed manual scale factor in place of the ramp. It can be disabled completely, in which case samples pass through untouched. All state runs on a single sync clock. The amplitude path is combinational from the sample input and the current scale to the sample output.

Top module: `keying_ramp`

## Requirements
- R1: With `mult_en` low, `sample_out` equals `sample_in` bit for bit.
- R2: With `mult_en` high and `auto_mode` low, the applied scale is `manual_scale`. While `mult_en` and `auto_mode` are not both high, `ramp_scale` keeps its value.
- R3: With `mult_en` and `auto_mode` both high, each timer timeout moves `ramp_scale` by exactly one unit. The step is upward when `key_in` is 1 and `ramp_scale` is below `full_scale`. It is downward when `key_in` is 0 and `ramp_scale` is above zero. At each timeout, `key_in` is sampled on that rising edge.
- R4: While shaping is active, timeouts occur every max(`ramp_rate`,1) clock cycles, so a rate of 0 behaves as 1. While inactive or in reset, the timer rests at 1, so the first active edge is a timeout. Between timeouts, `ramp_scale` does not change.
- R5: With `upd_reload_en` at 0, `upd_strobe` has no effect. With it at 1, a strobe on a non-timeout edge restarts the interval, so the next timeout comes max(`ramp_rate`,1) cycles later.
- R6: The ramp stops at zero going down and at `full_scale` going up. If `full_scale` is lowered below the current scale while keyed, the scale steps down to it.
- R7: When multiplying, `sample_out` = trunc(`sample_in` × scale / 2^14), rounded toward zero for negative samples. Samples and output are two's complement.
- R8: `at_limit` is 1 exactly when `ramp_scale` equals the current destination: `full_scale` if `key_in` is 1, zero otherwise.
- R9: Synchronous reset (`rst` high) clears `ramp_scale` to 0 and returns the timer to its resting count of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sync clock |
| rst | input | 1 | Synchronous reset, active high |
| mult_en | input | 1 | Enables the amplitude multiplier |
| auto_mode | input | 1 | 1 = ramped scale, 0 = manual scale |
| upd_reload_en | input | 1 | Lets the update strobe restart the rate timer |
| key_in | input | 1 | Keying input: 1 ramps up, 0 ramps down |
| upd_strobe | input | 1 | Update strobe |
| ramp_rate | input | 8 | Cycles per ramp step (0 acts as 1) |
| manual_scale | input | 14 | Fixed scale used when auto_mode is 0 |
| full_scale | input | 14 | Upper destination of the ramp |
| sample_in | input | 10 | Signed input sample |
| sample_out | output | 10 | Signed scaled sample |
| ramp_scale | output | 14 | Current ramp counter value |
| at_limit | output | 1 | Ramp counter is at its destination |

## Verification
The sample input changes every cycle with a pseudo-random signed value, so each clock checks the multiply and its rounding on fresh positive, negative and extreme operands. The ramp is run up and down at a rate of 3, and again at a rate of 0. This tells a correct step period apart from an off-by-one timer or a missing zero-rate guard. Update strobes are applied once with reloading disabled and once with it enabled, which separates an ignored strobe from one that restarts the interval. A full-scale value lowered under a keyed ramp, together with manual and bypass phases, exposes wrong limit handling, wrong scale selection and a leaky bypass.

// File: rtl/keyramp_pkg.sv
package keyramp_pkg;
   typedef enum logic {
      RAMP_DOWN = 1'b0,
      RAMP_UP   = 1'b1
   } ramp_dir_e;
endpackage

// File: rtl/kr_rate_timer.sv
module kr_rate_timer #(
   parameter int RATE_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              active,
   input  logic              upd,
   input  logic              reload_on_upd,
   input  logic [RATE_W-1:0] rate,
   output logic              tick
);
   localparam logic [RATE_W-1:0] ONE = RATE_W'(1);

   logic [RATE_W-1:0] cnt;
   logic [RATE_W-1:0] reload_val;

   assign reload_val = (rate == '0) ? ONE : rate;
   assign tick       = active && (cnt == ONE);

   always_ff @(posedge clk) begin
      if (rst)                        cnt <= ONE;
      else if (!active)               cnt <= ONE;
      else if (tick)                  cnt <= reload_val;
      else if (upd && reload_on_upd)  cnt <= reload_val;
      else                            cnt <= cnt - ONE;
   end

   // strobe without reload permission leaves the countdown alone
   assert_upd_ignored_R5: assert property (@(posedge clk) disable iff (rst)
      (active && upd && !reload_on_upd && cnt != ONE) |=> (cnt == $past(cnt) - ONE));

   // strobe with reload permission restarts the interval
   assert_upd_reload_R5: assert property (@(posedge clk) disable iff (rst)
      (active && upd && reload_on_upd) |=> (cnt == $past(reload_val)));

   // the count never reaches zero
   assert_never_zero_R4: assert property (@(posedge clk) disable iff (rst)
      cnt != '0);
endmodule

// File: rtl/kr_scale_counter.sv
module kr_scale_counter
   import keyramp_pkg::*;
#(
   parameter int SCALE_W = 14
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               tick,
   input  ramp_dir_e          dir,
   input  logic [SCALE_W-1:0] full,
   output logic [SCALE_W-1:0] scale,
   output logic               at_limit
);
   localparam logic [SCALE_W-1:0] UNIT = SCALE_W'(1);

   logic [SCALE_W-1:0] target;

   assign target   = (dir == RAMP_UP) ? full : '0;
   assign at_limit = (scale == target);

   always_ff @(posedge clk) begin
      if (rst) begin
         scale <= '0;
      end else if (tick) begin
         if (scale < target)      scale <= scale + UNIT;
         else if (scale > target) scale <= scale - UNIT;
      end
   end

   assert_unit_step_R3: assert property (@(posedge clk) disable iff (rst)
      tick |=> (scale == $past(scale) || scale == $past(scale) + UNIT
                || scale == $past(scale) - UNIT));

   assert_hold_between_R4: assert property (@(posedge clk) disable iff (rst)
      !tick |=> $stable(scale));

   assert_floor_R6: assert property (@(posedge clk) disable iff (rst)
      (tick && dir == RAMP_DOWN && scale == '0) |=> (scale == '0));

   assert_ceiling_R6: assert property (@(posedge clk) disable iff (rst)
      (tick && dir == RAMP_UP && scale == full) |=> (scale == $past(full)));
endmodule

// File: rtl/kr_scaler.sv
module kr_scaler #(
   parameter int SAMPLE_W       = 10,
   parameter int SCALE_W        = 14,
   parameter bit SIGNED_SAMPLES = 1'b1
) (
   input  logic [SAMPLE_W-1:0] sample_in,
   input  logic [SCALE_W-1:0]  scale,
   output logic [SAMPLE_W-1:0] sample_out
);
   localparam int PW = SAMPLE_W + SCALE_W + 1;

   generate
      if (SIGNED_SAMPLES) begin : g_signed
         logic signed [PW-1:0] prod;
         logic signed [PW-1:0] bias;
         logic signed [PW-1:0] biased;

         assign prod   = PW'($signed(sample_in)) * $signed(PW'({1'b0, scale}));
         assign bias   = prod[PW-1] ? {{(PW-SCALE_W){1'b0}}, {SCALE_W{1'b1}}} : '0;
         assign biased = prod + bias;
         assign sample_out = SAMPLE_W'(biased >>> SCALE_W);

         // truncation toward zero never grows the magnitude or flips the sign
         always_comb begin
            if (!$signed(sample_in)[SAMPLE_W-1]) begin
               assert_shrink_pos_R7: assert (!sample_out[SAMPLE_W-1] &&
                  ($signed(sample_out) <= $signed(sample_in)));
            end else begin
               assert_shrink_neg_R7: assert (($signed(sample_out) <= 0) &&
                  ($signed(sample_out) >= $signed(sample_in)));
            end
         end
      end else begin : g_unsigned
         logic [PW-2:0] uprod;
         assign uprod      = (PW-1)'(sample_in) * (PW-1)'(scale);
         assign sample_out = SAMPLE_W'(uprod >> SCALE_W);
      end
   endgenerate
endmodule

// File: rtl/keying_ramp.sv
module keying_ramp
   import keyramp_pkg::*;
#(
   parameter int SAMPLE_W       = 10,
   parameter int SCALE_W        = 14,
   parameter int RATE_W         = 8,
   parameter bit SIGNED_SAMPLES = 1'b1
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                mult_en,
   input  logic                auto_mode,
   input  logic                upd_reload_en,
   input  logic                key_in,
   input  logic                upd_strobe,
   input  logic [RATE_W-1:0]   ramp_rate,
   input  logic [SCALE_W-1:0]  manual_scale,
   input  logic [SCALE_W-1:0]  full_scale,
   input  logic [SAMPLE_W-1:0] sample_in,
   output logic [SAMPLE_W-1:0] sample_out,
   output logic [SCALE_W-1:0]  ramp_scale,
   output logic                at_limit
);
   generate
      if (SAMPLE_W < 2 || SAMPLE_W > 32) begin : g_bad_sample_w
         $error("keying_ramp: SAMPLE_W out of range");
      end
      if (SCALE_W < 2 || SCALE_W > 24) begin : g_bad_scale_w
         $error("keying_ramp: SCALE_W out of range");
      end
      if (RATE_W < 1 || RATE_W > 32) begin : g_bad_rate_w
         $error("keying_ramp: RATE_W out of range");
      end
   endgenerate

   logic               active;
   logic               tick;
   logic [SCALE_W-1:0] eff_scale;
   logic [SAMPLE_W-1:0] scaled;
   ramp_dir_e          dir;

   assign active    = mult_en && auto_mode;
   assign dir       = key_in ? RAMP_UP : RAMP_DOWN;
   assign eff_scale = auto_mode ? ramp_scale : manual_scale;

   kr_rate_timer #(.RATE_W(RATE_W)) u_timer (
      .clk           (clk),
      .rst           (rst),
      .active        (active),
      .upd           (upd_strobe),
      .reload_on_upd (upd_reload_en),
      .rate          (ramp_rate),
      .tick          (tick)
   );

   kr_scale_counter #(.SCALE_W(SCALE_W)) u_counter (
      .clk      (clk),
      .rst      (rst),
      .tick     (tick),
      .dir      (dir),
      .full     (full_scale),
      .scale    (ramp_scale),
      .at_limit (at_limit)
   );

   kr_scaler #(
      .SAMPLE_W       (SAMPLE_W),
      .SCALE_W        (SCALE_W),
      .SIGNED_SAMPLES (SIGNED_SAMPLES)
   ) u_scaler (
      .sample_in  (sample_in),
      .scale      (eff_scale),
      .sample_out (scaled)
   );

   assign sample_out = mult_en ? scaled : sample_in;

   // the ramp counter is frozen whenever shaping is not active
   assert_frozen_inactive_R2: assert property (@(posedge clk) disable iff (rst)
      !active |=> $stable(ramp_scale));

   // reset leaves the counter at zero
   assert_reset_zero_R9: assert property (@(posedge clk)
      rst |=> (ramp_scale == '0));
endmodule

// File: tb/tb_keying_ramp.sv
module tb_keying_ramp;
   logic        clk = 1'b0;
   logic        rst;
   logic        mult_en, auto_mode, upd_reload_en, key_in, upd_strobe;
   logic [7:0]  ramp_rate;
   logic [13:0] manual_scale, full_scale;
   logic [9:0]  sample_in;
   logic [9:0]  sample_out;
   logic [13:0] ramp_scale;
   logic        at_limit;

   keying_ramp dut (
      .clk (clk), .rst (rst), .mult_en (mult_en), .auto_mode (auto_mode),
      .upd_reload_en (upd_reload_en), .key_in (key_in), .upd_strobe (upd_strobe),
      .ramp_rate (ramp_rate), .manual_scale (manual_scale), .full_scale (full_scale),
      .sample_in (sample_in), .sample_out (sample_out), .ramp_scale (ramp_scale),
      .at_limit (at_limit)
   );

   always #5 clk = ~clk;

   int          n_cmp = 0;
   int          n_bad = 0;
   int          m_tmr = 1;
   int          m_scl = 0;
   bit          finished = 1'b0;
   logic [31:0] seed = 32'h1234_5678;
   string       tag = "R9";

   // behavioural reference, advanced once per rising edge
   task automatic model_edge();
      int r, tgt;
      r = (ramp_rate == 0) ? 1 : int'(ramp_rate);
      if (rst) begin
         m_tmr = 1; m_scl = 0;
      end else if (mult_en && auto_mode) begin
         if (m_tmr == 1) begin
            m_tmr = r;
            tgt = key_in ? int'(full_scale) : 0;
            if (m_scl < tgt) m_scl++;
            else if (m_scl > tgt) m_scl--;
         end else if (upd_strobe && upd_reload_en) begin
            m_tmr = r;
         end else begin
            m_tmr--;
         end
      end else begin
         m_tmr = 1;
      end
   endtask

   task automatic compare();
      int s, eff, exp_out, got_out, exp_lim;
      s = int'($signed(sample_in));
      eff = auto_mode ? m_scl : int'(manual_scale);
      exp_out = mult_en ? (s * eff) / 16384 : s;
      got_out = int'($signed(sample_out));
      exp_lim = (m_scl == (key_in ? int'(full_scale) : 0)) ? 1 : 0;
      n_cmp++;
      if (got_out != exp_out) begin
         n_bad++;
         $display("FAIL %s sample_out got %0d expected %0d (R7 rounding/R1 bypass)", tag, got_out, exp_out);
      end
      n_cmp++;
      if (int'(ramp_scale) != m_scl) begin
         n_bad++;
         $display("FAIL %s ramp_scale got %0d expected %0d", tag, ramp_scale, m_scl);
      end
      n_cmp++;
      if (int'(at_limit) != exp_lim) begin
         n_bad++;
         $display("FAIL R8 (%s) at_limit got %0d expected %0d", tag, at_limit, exp_lim);
      end
   endtask

   task automatic step(int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         model_edge();
         @(negedge clk);
         compare();
         seed = seed * 32'd1103515245 + 32'd12345;
         case (seed[31:29])
            3'd0:    sample_in = 10'h200;
            3'd1:    sample_in = 10'h1FF;
            default: sample_in = seed[25:16];
         endcase
      end
   endtask

   task automatic pulse_upd(int cycles, int every);
      for (int i = 0; i < cycles; i++) begin
         upd_strobe = ((i % every) == 0);
         step(1);
      end
      upd_strobe = 1'b0;
   endtask

   initial begin
      rst = 1'b1; mult_en = 1'b1; auto_mode = 1'b1; upd_reload_en = 1'b0;
      key_in = 1'b0; upd_strobe = 1'b0; ramp_rate = 8'd3;
      manual_scale = 14'd0; full_scale = 14'd12; sample_in = 10'd100;
      // R9: reset state
      tag = "R9"; step(3);
      rst = 1'b0;
      // R1: bypass with multiplier disabled, key high must not move the ramp
      tag = "R1"; mult_en = 1'b0; key_in = 1'b1; step(20);
      // R2: manual scale at one half, then near unity
      tag = "R2"; mult_en = 1'b1; auto_mode = 1'b0; manual_scale = 14'd8192; step(20);
      manual_scale = 14'd16383; step(10);
      // R7: odd manual scale to exercise truncation of negative products
      tag = "R7"; manual_scale = 14'd5001; step(30);
      // R3/R4: ramp up at rate 3, dwell at top, then ramp down
      tag = "R3"; auto_mode = 1'b1; key_in = 1'b1; step(45);
      tag = "R3"; key_in = 1'b0; step(45);
      // R4: rate 0 behaves as rate 1
      tag = "R4"; ramp_rate = 8'd0; full_scale = 14'd5; key_in = 1'b1; step(10);
      key_in = 1'b0; step(8);
      // R5: strobes ignored without reload permission
      tag = "R5"; ramp_rate = 8'd4; full_scale = 14'd40; key_in = 1'b1;
      upd_reload_en = 1'b0; pulse_upd(30, 3);
      // R5: strobes restart the interval, stalling the ramp
      upd_reload_en = 1'b1; pulse_upd(16, 2);
      pulse_upd(12, 5);
      step(8);
      // R6: lower full scale under a keyed ramp, then floor at zero
      tag = "R6"; ramp_rate = 8'd1; full_scale = 14'd20; step(30);
      full_scale = 14'd6; step(20);
      key_in = 1'b0; step(15);
      // R2: leaving auto mode freezes the ramp counter
      tag = "R2"; key_in = 1'b1; auto_mode = 1'b0; manual_scale = 14'd300; step(10);
      // R9: reset in the middle of a ramp
      tag = "R9"; auto_mode = 1'b1; step(6); rst = 1'b1; step(2); rst = 1'b0; step(5);
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #2000000;
      if (!finished) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog (%s) got timeout expected completion", tag);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule